// File: doc/BRIEF.md
# AM824 Sample Labeler

This block turns 16-bit PCM samples, delivered as a little-endian byte pair, into 32-bit AM824 quadlets for an isochronous audio stream. The sample is left-justified into the 24-bit data field, and an 8-bit label is placed in the top byte. In raw multichannel mode the label is the fixed multibit-linear audio code. In the two IEC958 modes, PCM and compressed non-audio, the label carries four live bits per subframe: a block-start marker, a first-subframe flag, an even-parity bit and one bit of the serialized channel-status block.

The channel-status block spans 192 frames. The block keeps its own frame counter, which moves forward once per event, on the strobe that marks the last channel of that event. Frame 0 carries the non-audio flag. Frames 24 to 27 carry the four-bit sample-rate code, most significant bit first. Every other frame carries 0. The upstream packer gives each sample its channel index and marks the last channel of each event. The labeled quadlet appears one clock later, most significant byte first.

Top module: `am824_labeler`

## Requirements
- R1: While reset is held and until the first accepted sample, out_valid is 0 and out_quad is 0. After reset the frame counter starts at frame 0.
- R2: A sample accepted with in_valid produces out_valid high exactly one cycle later, with out_quad[23:0] = {in_byte_hi, in_byte_lo, 8'h00}. out_valid is low in every cycle that follows a cycle without in_valid.
- R3: With fmt_sel = 2'b00 (raw), out_quad[31:24] is 8'h40 whatever the channel or frame.
- R4: With fmt_sel = 2'b01 (PCM) or 2'b10 (non-audio), out_quad[31:30] and out_quad[25:24] are 0. Bit 29 is block start, bit 28 is set when in_chan is 0, bit 27 is parity and bit 26 is the channel-status bit.
- R5: Block start (bit 29) is 1 only for channel 0 of frame 0.
- R6: In the IEC958 modes, the parity bit is chosen so that the 24 sample bits, the channel-status bit and the parity bit together hold an even number of ones.
- R7: In frame 0 the channel-status bit is 1 for fmt_sel = 2'b10 and 0 for fmt_sel = 2'b01.
- R8: In frames 24, 25, 26 and 27 the channel-status bit is rate_code[3], [2], [1] and [0] respectively.
- R9: In every frame other than 0 and 24 to 27, the channel-status bit is 0.
- R10: The frame counter advances only when in_valid and in_event_last are both high, and wraps from 191 to 0. in_event_last without in_valid has no effect.
- R11: fmt_sel = 2'b11 is reserved and is labeled exactly as raw (8'h40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_byte_lo | input | 8 | Low byte of the 16-bit PCM sample |
| in_byte_hi | input | 8 | High byte of the 16-bit PCM sample |
| in_chan | input | 3 | Channel (subframe) index within the event |
| in_event_last | input | 1 | Marks the last channel of the event |
| fmt_sel | input | 2 | 0 raw, 1 IEC958 PCM, 2 IEC958 non-audio, 3 reserved |
| rate_code | input | 4 | Sample-rate code placed in the channel-status block |
| out_valid | output | 1 | Quadlet valid |
| out_quad | output | 32 | Labeled AM824 quadlet |

## Verification
The bench aims at the edges of the 192-frame block. It checks the rate bits in frames 24 to 27 against several codes and checks that no stray channel-status bit appears in any other frame. A counter that is off by one would shift the rate code into the wrong frames. A counter that wraps at the wrong point would move block start away from frame 0 in the second and third blocks. The bench also injects end-of-event strobes with no valid sample. A design that counted those strobes would drift out of step with the model. Parity is checked against every sample pattern in a sweep, so a parity tree that left out the channel-status bit or a sample byte shows up as soon as that bit is set.

// File: rtl/am824_pkg.sv
package am824_pkg;
  typedef enum logic [1:0] {
    FMT_RAW      = 2'b00,
    FMT_PCM      = 2'b01,
    FMT_NONAUDIO = 2'b10,
    FMT_RSVD     = 2'b11
  } fmt_e;

  function automatic logic fmt_is_iec(input logic [1:0] f);
    return (f == FMT_PCM) || (f == FMT_NONAUDIO);
  endfunction
endpackage

// File: rtl/am824_frame_counter.sv
module am824_frame_counter #(
  parameter int FRAMES = 192,
  localparam int CNT_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [CNT_W-1:0] frame_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_d;
  end

  assign frame_o = cnt_q;

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_cnt_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && cnt_q == LAST) |=> (cnt_q == '0));
  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/am824_status_bit.sv
module am824_status_bit #(
  parameter int FRAMES     = 192,
  parameter int RATE_W     = 4,
  parameter int RATE_FIRST = 24,
  localparam int CNT_W     = $clog2(FRAMES),
  localparam int RATE_LAST = RATE_FIRST + RATE_W - 1,
  localparam int RIDX_W    = (RATE_W > 1) ? $clog2(RATE_W) : 1
) (
  input  logic [CNT_W-1:0]  frame_i,
  input  logic [1:0]        fmt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              cs_bit_o
);
  import am824_pkg::*;

  logic             in_window;
  logic [CNT_W-1:0] rate_off;

  always_comb begin
    in_window = (frame_i >= CNT_W'(RATE_FIRST)) && (frame_i <= CNT_W'(RATE_LAST));
    rate_off  = CNT_W'(RATE_LAST) - frame_i;
    if (frame_i == '0)
      cs_bit_o = (fmt_i == FMT_NONAUDIO);
    else if (in_window)
      cs_bit_o = rate_i[rate_off[RIDX_W-1:0]];
    else
      cs_bit_o = 1'b0;
  end
endmodule

// File: rtl/am824_label_former.sv
module am824_label_former #(
  parameter int         SAMPLE_W  = 16,
  parameter int         CH_W      = 3,
  parameter logic [7:0] RAW_LABEL = 8'h40,
  localparam int        FIELD_W   = 24,
  localparam int        PAD_W     = FIELD_W - SAMPLE_W
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                first_frame_i,
  input  logic                cs_bit_i,
  input  logic [1:0]          fmt_i,
  output logic [31:0]         quad_o
);
  import am824_pkg::*;

  logic [FIELD_W-1:0] field;
  logic               par;
  logic               sub0;
  logic [7:0]         label;

  always_comb begin
    field = {sample_i, {PAD_W{1'b0}}};
    par   = cs_bit_i;
    for (int i = 0; i < SAMPLE_W; i++) par = par ^ sample_i[i];
    sub0  = (chan_i == '0);
    if (fmt_is_iec(fmt_i))
      label = {2'b00, first_frame_i & sub0, sub0, par, cs_bit_i, 2'b00};
    else
      label = RAW_LABEL;
    quad_o = {label, field};
  end
endmodule

// File: rtl/am824_labeler.sv
module am824_labeler #(
  parameter int FRAMES     = 192,
  parameter int RATE_W     = 4,
  parameter int RATE_FIRST = 24,
  parameter int CH_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte_lo,
  input  logic [7:0]        in_byte_hi,
  input  logic [CH_W-1:0]   in_chan,
  input  logic              in_event_last,
  input  logic [1:0]        fmt_sel,
  input  logic [RATE_W-1:0] rate_code,
  output logic              out_valid,
  output logic [31:0]       out_quad
);
  import am824_pkg::*;

  localparam int CNT_W = $clog2(FRAMES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  logic [CNT_W-1:0] frame;
  logic             adv;
  logic             cs_bit;
  logic [31:0]      quad_d;

  assign adv = in_valid & in_event_last;

  am824_frame_counter #(.FRAMES(FRAMES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .adv_i   (adv),
    .frame_o (frame)
  );

  am824_status_bit #(
    .FRAMES(FRAMES), .RATE_W(RATE_W), .RATE_FIRST(RATE_FIRST)
  ) u_cs (
    .frame_i  (frame),
    .fmt_i    (fmt_sel),
    .rate_i   (rate_code),
    .cs_bit_o (cs_bit)
  );

  am824_label_former #(.SAMPLE_W(16), .CH_W(CH_W)) u_lbl (
    .sample_i      ({in_byte_hi, in_byte_lo}),
    .chan_i        (in_chan),
    .first_frame_i (frame == '0),
    .cs_bit_i      (cs_bit),
    .fmt_i         (fmt_sel),
    .quad_o        (quad_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      out_quad  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_quad <= quad_d;
    end
  end

  assert_valid_lat_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);
  assert_raw_label_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !fmt_is_iec(fmt_sel)) |=> (out_quad[31:24] == 8'h40));
  assert_blk_sub0_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_quad[29]) |-> out_quad[28]);
  assert_even_parity_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && fmt_is_iec(fmt_sel)) |=> !(^{out_quad[27:26], out_quad[23:0]}));
  assert_cs_quiet_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && fmt_is_iec(fmt_sel) && frame != '0 &&
     (frame < CNT_W'(RATE_FIRST) || frame > CNT_W'(RATE_FIRST + RATE_W - 1)))
    |=> !out_quad[26]);
endmodule

// File: tb/test_am824_labeler.sv
module test_am824_labeler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte_lo, in_byte_hi;
  logic [2:0]  in_chan;
  logic        in_event_last;
  logic [1:0]  fmt_sel;
  logic [3:0]  rate_code;
  logic        out_valid;
  logic [31:0] out_quad;

  int checks = 0;
  int failures = 0;
  int frame_m = 0;
  int seq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  am824_labeler i_am824_labeler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_byte_lo(in_byte_lo), .in_byte_hi(in_byte_hi), .in_chan(in_chan),
    .in_event_last(in_event_last), .fmt_sel(fmt_sel), .rate_code(rate_code),
    .out_valid(out_valid), .out_quad(out_quad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cs_model(input int fr, input logic [1:0] f, input logic [3:0] rc);
    if (fr == 0) return f == 2'b10;
    if (fr >= 24 && fr <= 27) return rc[27 - fr];
    return 1'b0;
  endfunction

  task automatic send(input logic [7:0] lo, input logic [7:0] hi, input int ch, input bit last);
    logic [23:0] samp;
    logic        iec, csb, par, sub0, blk;
    @(negedge clk);
    in_valid = 1; in_byte_lo = lo; in_byte_hi = hi;
    in_chan = 3'(ch); in_event_last = last;
    @(negedge clk);
    in_valid = 0; in_event_last = 0;
    samp = {hi, lo, 8'h00};
    iec  = (fmt_sel == 2'b01) || (fmt_sel == 2'b10);
    csb  = cs_model(frame_m, fmt_sel, rate_code);
    par  = (^samp) ^ csb;
    sub0 = (ch == 0);
    blk  = (frame_m == 0) && sub0;
    chk("R2 valid", 32'(out_valid), 32'd1);
    chk("R2 sample", 32'(out_quad[23:0]), 32'(samp));
    if (!iec) begin
      if (fmt_sel == 2'b11) chk("R11 reserved label", 32'(out_quad[31:24]), 32'h40);
      else                  chk("R3 raw label", 32'(out_quad[31:24]), 32'h40);
    end else begin
      chk("R4 fixed zeros", 32'({out_quad[31:30], out_quad[25:24]}), 32'd0);
      chk("R4 subframe flag", 32'(out_quad[28]), 32'(sub0));
      chk("R5 block start", 32'(out_quad[29]), 32'(blk));
      chk("R6 parity", 32'(out_quad[27]), 32'(par));
      if (frame_m == 0)                      chk("R7 frame0 status", 32'(out_quad[26]), 32'(csb));
      else if (frame_m >= 24 && frame_m <= 27) chk("R8 rate status", 32'(out_quad[26]), 32'(csb));
      else                                   chk("R9 quiet status", 32'(out_quad[26]), 32'(csb));
      if (seq > 400 && frame_m == 0 && sub0)
        chk("R10 wrap block start", 32'(out_quad[29]), 32'd1);
    end
    if (last) frame_m = (frame_m == 191) ? 0 : frame_m + 1;
    seq++;
  endtask

  task automatic run(input logic [1:0] f, input logic [3:0] rc, input int nch, input int nfr);
    fmt_sel = f; rate_code = rc;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int c = 0; c < nch; c++) begin
        logic [15:0] v;
        v = 16'(seq * 16'h9E37 + (seq >> 3) * 16'h1F1);
        send(v[7:0], v[15:8], c, c == nch - 1);
      end
      if (fr % 37 == 5) begin
        // R10: a lone end-of-event strobe must not move the counter
        @(negedge clk);
        in_event_last = 1;
        @(negedge clk);
        in_event_last = 0;
        chk("R2 idle no valid", 32'(out_valid), 32'd0);
      end
    end
  endtask

  initial begin
    in_valid = 0; in_byte_lo = 0; in_byte_hi = 0; in_chan = 0;
    in_event_last = 0; fmt_sel = 2'b01; rate_code = 4'hC;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset quad", out_quad, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release valid", 32'(out_valid), 32'd0);
    chk("R1 after release quad", out_quad, 32'd0);
    run(2'b01, 4'hC, 2, 400);
    run(2'b10, 4'h4, 2, 200);
    run(2'b01, 4'hA, 2, 200);
    run(2'b10, 4'h5, 2, 200);
    run(2'b01, 4'h0, 2, 200);
    run(2'b00, 4'hF, 6, 60);
    run(2'b11, 4'hF, 4, 20);
    run(2'b01, 4'h3, 2, 200);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule